// File: doc/BRIEF.md
# Coherent Data-Cache Tag Controller

This block owns the tag and coherence-state array of an 8-way set-associative data cache with 128 sets and lines of 8 words. Each way of each set holds one address tag and a two-bit state. A line is Invalid, Exclusive (clean) or Modified (dirty). There is no shared state. The array has a single port. In every cycle the block decides which of four sources uses it: a bus snoop, a flash-invalidate sweep, a per-line invalidate, or a load/store lookup. A load/store request that loses arbitration is stalled and must be held until it is accepted.

A load/store lookup reports hit and way one cycle after it is accepted. On a miss the block allocates a way, using the lowest-numbered invalid way or, if there is none, the victim way supplied by an external replacement unit. A snoop that hits dirty data raises a castout request towards a write-back buffer. It also blocks the load/store side for one extra cycle while the line is copied out. Every state write is reported on an update port. An enable input and a lock input control whether lookups hit and whether misses allocate. Data storage and the replacement policy live outside this block.

Top module: `mei_tag_ctrl`

## Requirements
- R1: A load/store lookup accepted in cycle N reports `rsp_valid`=1 after the next clock edge. `rsp_hit` is 1 only when a way of the indexed set holds the request tag in a non-Invalid state, and `rsp_way` names that way. At most one way ever matches.
- R2: States are encoded as Invalid=2'b00, Exclusive=2'b01 and Modified=2'b10. The value 2'b11 is never written. Each state write is reported one cycle later on `upd_valid`/`upd_index`/`upd_way`/`upd_state`.
- R3: A snoop always takes the port. A load/store request present in the same cycle sees `ls_stall`=1 and is accepted no earlier than the following cycle.
- R4: A snoop that hits a Modified line raises `co_valid` with the set and way one cycle later. The line becomes Invalid for an invalidating snoop and Exclusive for a read snoop. `ls_stall` stays high for one further cycle after the snoop.
- R5: A snoop that hits an Exclusive line never raises a castout. An invalidating snoop makes the line Invalid, and a read snoop leaves it Exclusive with no state write.
- R6: On an enabled, unlocked miss, the block writes the tag into the lowest-numbered Invalid way, or into `victim_way` when all eight ways are valid. A load sets the state to Exclusive and a store sets it to Modified. Replacing a Modified victim raises `co_valid` for that set and way.
- R7: A store that hits an Exclusive line changes it to Modified. A store that hits a Modified line causes no state write.
- R8: A one-cycle `flash_req` sets `flash_busy` for exactly 128 cycles, clearing one set per cycle. Load/store requests stall while `flash_busy` is high, and every line is Invalid afterwards.
- R9: `linv_valid` writes Invalid into way `linv_way` of set `linv_index`. It takes the port ahead of load/store, which stalls for that cycle.
- R10: With `cache_en`=0, lookups and snoops report no hit and write no state. Contents are preserved, so re-enabling finds the earlier lines.
- R11: With `cache_lock`=1, a miss allocates nothing and writes no state, while hits still report and still update state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable |
| cache_lock | input | 1 | Freeze contents on misses |
| flash_req | input | 1 | Start whole-array invalidate |
| ls_valid | input | 1 | Load/store request present |
| ls_index | input | 7 | Set index of request |
| ls_tag | input | 20 | Address tag of request |
| ls_write | input | 1 | 1 = store, 0 = load |
| victim_way | input | 3 | Replacement choice when set is full |
| ls_stall | output | 1 | Request not accepted this cycle |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Hit way, or allocated way on a miss |
| snp_valid | input | 1 | Snoop present |
| snp_index | input | 7 | Snoop set index |
| snp_tag | input | 20 | Snoop tag |
| snp_inval | input | 1 | 1 = invalidating snoop, 0 = read snoop |
| snp_hit | output | 1 | Previous-cycle snoop hit |
| linv_valid | input | 1 | Per-line invalidate |
| linv_index | input | 7 | Set to invalidate |
| linv_way | input | 3 | Way to invalidate |
| co_valid | output | 1 | Castout request |
| co_index | output | 7 | Castout set |
| co_way | output | 3 | Castout way |
| upd_valid | output | 1 | State write happened |
| upd_index | output | 7 | Written set |
| upd_way | output | 3 | Written way |
| upd_state | output | 2 | New state |
| flash_busy | output | 1 | Flash sweep in progress |

## Verification
The bench aims at collisions on the single port. It presents a snoop and a load in the same cycle and then checks the extra blocked cycle after a dirty snoop hit. A design that dropped the held request, or that released it one cycle early, would return a response too soon or never. It separates read snoops from invalidating snoops on both clean and dirty lines. A wrong transition table shows up as a missing castout, a spurious state write, or a line that still hits afterwards. The bench fills a set so that allocation must use the external victim way, including a dirty victim. It then counts the flash sweep cycle by cycle, so an off-by-one sweep or a skipped set is caught. Disabled and locked operation are checked for hits that are not reported and for writes that should not occur.

// File: rtl/mei_pkg.sv
package mei_pkg;
   typedef enum logic [1:0] {
      ST_INV = 2'b00,
      ST_EXC = 2'b01,
      ST_MOD = 2'b10
   } mei_state_e;

   // next state of a line hit by a snoop
   function automatic logic [1:0] snoop_next(input logic [1:0] cur, input logic inval);
      if (inval)
         return ST_INV;
      else if (cur == ST_MOD)
         return ST_EXC;
      else
         return cur;
   endfunction
endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store
   import mei_pkg::*;
#(
   parameter int SETS = 128,
   parameter int WAYS = 8,
   parameter int TAGW = 20,
   localparam int IW = $clog2(SETS),
   localparam int WW = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IW-1:0]              rd_idx,
   output logic [WAYS-1:0][TAGW-1:0]  rd_tags,
   output logic [WAYS-1:0][1:0]       rd_states,
   input  logic                       wr_en,
   input  logic [IW-1:0]              wr_idx,
   input  logic [WW-1:0]              wr_way,
   input  logic                       wr_tag_en,
   input  logic [TAGW-1:0]            wr_tag,
   input  logic [1:0]                 wr_state,
   input  logic                       clr_en,
   input  logic [IW-1:0]              clr_idx
);
   logic [TAGW-1:0] tag_q   [SETS][WAYS];
   logic [1:0]      state_q [SETS][WAYS];

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         rd_tags[w]   = tag_q[rd_idx][w];
         rd_states[w] = state_q[rd_idx][w];
      end
   end

   // tags carry no reset: a line is meaningful only through its state
   always_ff @(posedge clk) begin
      if (wr_en && wr_tag_en)
         tag_q[wr_idx][wr_way] <= wr_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               state_q[s][w] <= ST_INV;
      end else begin
         if (clr_en)
            for (int w = 0; w < WAYS; w++)
               state_q[clr_idx][w] <= ST_INV;
         if (wr_en)
            state_q[wr_idx][wr_way] <= wr_state;
      end
   end

   assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_state != 2'b11));
   assert_no_sweep_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> !wr_en);
endmodule

// File: rtl/mei_way_match.sv
module mei_way_match
   import mei_pkg::*;
#(
   parameter int WAYS = 8,
   parameter int TAGW = 20,
   localparam int WW = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       look_en,
   input  logic [TAGW-1:0]            tag_in,
   input  logic [WAYS-1:0][TAGW-1:0]  tags,
   input  logic [WAYS-1:0][1:0]       states,
   output logic                       hit,
   output logic [WW-1:0]              hit_way,
   output logic                       any_inv,
   output logic [WW-1:0]              inv_way
);
   logic [WAYS-1:0] hit_vec;
   logic [WAYS-1:0] inv_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = look_en && (states[w] != ST_INV) && (tags[w] == tag_in);
      assign inv_vec[w] = (states[w] == ST_INV);
   end

   // lowest-numbered set bit wins in both encoders
   always_comb begin
      hit_way = '0;
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) hit_way = WW'(w);
         if (inv_vec[w]) inv_way = WW'(w);
      end
   end

   assign hit     = |hit_vec;
   assign any_inv = |inv_vec;

   assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/mei_port_arb.sv
module mei_port_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic snp_req,
   input  logic flash_req,
   input  logic flash_busy,
   input  logic co_block,
   input  logic linv_req,
   input  logic ls_req,
   output logic gnt_snp,
   output logic gnt_linv,
   output logic gnt_ls,
   output logic ls_stall
);
   logic port_held;

   // fixed priority: snoop, flash sweep, castout copy, line invalidate, load/store
   assign port_held = flash_busy | flash_req | co_block;
   assign gnt_snp   = snp_req;
   assign gnt_linv  = linv_req & ~snp_req & ~port_held;
   assign gnt_ls    = ls_req & ~snp_req & ~port_held & ~linv_req;
   assign ls_stall  = ls_req & ~gnt_ls;

   assert_one_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_snp, gnt_linv, gnt_ls}));
endmodule

// File: rtl/mei_tag_ctrl.sv
module mei_tag_ctrl
   import mei_pkg::*;
#(
   parameter int SETS  = 128,
   parameter int WAYS  = 8,
   parameter int TAGW  = 20,
   parameter int WORDS = 8,
   localparam int IW = $clog2(SETS),
   localparam int WW = $clog2(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cache_en,
   input  logic            cache_lock,
   input  logic            flash_req,
   input  logic            ls_valid,
   input  logic [IW-1:0]   ls_index,
   input  logic [TAGW-1:0] ls_tag,
   input  logic            ls_write,
   input  logic [WW-1:0]   victim_way,
   output logic            ls_stall,
   output logic            rsp_valid,
   output logic            rsp_hit,
   output logic [WW-1:0]   rsp_way,
   input  logic            snp_valid,
   input  logic [IW-1:0]   snp_index,
   input  logic [TAGW-1:0] snp_tag,
   input  logic            snp_inval,
   output logic            snp_hit,
   input  logic            linv_valid,
   input  logic [IW-1:0]   linv_index,
   input  logic [WW-1:0]   linv_way,
   output logic            co_valid,
   output logic [IW-1:0]   co_index,
   output logic [WW-1:0]   co_way,
   output logic            upd_valid,
   output logic [IW-1:0]   upd_index,
   output logic [WW-1:0]   upd_way,
   output logic [1:0]      upd_state,
   output logic            flash_busy
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (TAGW < 1 || WORDS < 1) begin : g_bad_line
      $error("TAGW and WORDS must be positive");
   end

   logic                      gnt_snp, gnt_linv, gnt_ls;
   logic                      co_block;
   logic [IW-1:0]             sweep_idx;
   logic [IW-1:0]             rd_idx;
   logic [TAGW-1:0]           look_tag;
   logic [WAYS-1:0][TAGW-1:0] rd_tags;
   logic [WAYS-1:0][1:0]      rd_states;
   logic                      hit, any_inv;
   logic [WW-1:0]             hit_way, inv_way, alloc_way;
   logic [1:0]                hit_state, alloc_old;
   logic                      wr_en, wr_tag_en;
   logic [IW-1:0]             wr_idx;
   logic [WW-1:0]             wr_way;
   logic [1:0]                wr_state;
   logic                      co_now, blk_set, alloc_now;

   mei_port_arb u_arb (
      .clk(clk), .rst_n(rst_n), .snp_req(snp_valid), .flash_req(flash_req),
      .flash_busy(flash_busy), .co_block(co_block), .linv_req(linv_valid),
      .ls_req(ls_valid), .gnt_snp(gnt_snp), .gnt_linv(gnt_linv),
      .gnt_ls(gnt_ls), .ls_stall(ls_stall)
   );

   assign rd_idx   = snp_valid ? snp_index : ls_index;
   assign look_tag = snp_valid ? snp_tag : ls_tag;

   mei_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAGW(TAGW)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_tags(rd_tags),
      .rd_states(rd_states), .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way),
      .wr_tag_en(wr_tag_en), .wr_tag(ls_tag), .wr_state(wr_state),
      .clr_en(flash_busy), .clr_idx(sweep_idx)
   );

   mei_way_match #(.WAYS(WAYS), .TAGW(TAGW)) u_match (
      .clk(clk), .rst_n(rst_n), .look_en(cache_en & ~flash_busy),
      .tag_in(look_tag), .tags(rd_tags), .states(rd_states), .hit(hit),
      .hit_way(hit_way), .any_inv(any_inv), .inv_way(inv_way)
   );

   assign alloc_way = any_inv ? inv_way : victim_way;
   assign hit_state = rd_states[hit_way];
   assign alloc_old = rd_states[alloc_way];

   // one state write per cycle, chosen by the port owner
   always_comb begin
      wr_en     = 1'b0;
      wr_tag_en = 1'b0;
      wr_idx    = ls_index;
      wr_way    = hit_way;
      wr_state  = ST_INV;
      co_now    = 1'b0;
      blk_set   = 1'b0;
      alloc_now = 1'b0;
      if (gnt_snp) begin
         wr_idx = snp_index;
         if (hit) begin
            wr_state = snoop_next(hit_state, snp_inval);
            wr_en    = (wr_state != hit_state);
            co_now   = (hit_state == ST_MOD);
            blk_set  = (hit_state == ST_MOD);
         end
      end else if (gnt_linv) begin
         wr_idx   = linv_index;
         wr_way   = linv_way;
         wr_en    = cache_en;
      end else if (gnt_ls && cache_en) begin
         if (hit) begin
            wr_en    = ls_write && (hit_state == ST_EXC);
            wr_state = ST_MOD;
         end else if (!cache_lock) begin
            alloc_now = 1'b1;
            wr_en     = 1'b1;
            wr_tag_en = 1'b1;
            wr_way    = alloc_way;
            wr_state  = ls_write ? ST_MOD : ST_EXC;
            co_now    = (alloc_old == ST_MOD);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flash_busy <= 1'b0;
         sweep_idx  <= '0;
      end else if (flash_busy) begin
         if (sweep_idx == IW'(SETS - 1)) begin
            flash_busy <= 1'b0;
            sweep_idx  <= '0;
         end else begin
            sweep_idx <= sweep_idx + 1'b1;
         end
      end else if (flash_req) begin
         flash_busy <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_way   <= '0;
         snp_hit   <= 1'b0;
         co_valid  <= 1'b0;
         co_index  <= '0;
         co_way    <= '0;
         co_block  <= 1'b0;
         upd_valid <= 1'b0;
         upd_index <= '0;
         upd_way   <= '0;
         upd_state <= ST_INV;
      end else begin
         rsp_valid <= gnt_ls;
         rsp_hit   <= gnt_ls & hit;
         rsp_way   <= hit ? hit_way : (alloc_now ? alloc_way : '0);
         snp_hit   <= gnt_snp & hit;
         co_valid  <= co_now;
         co_index  <= wr_idx;
         co_way    <= wr_way;
         co_block  <= blk_set;
         upd_valid <= wr_en;
         upd_index <= wr_idx;
         upd_way   <= wr_way;
         upd_state <= wr_state;
      end
   end

   assert_snoop_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !gnt_ls);
   assert_castout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      co_block |=> !rsp_valid);
   assert_sweep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flash_busy |=> !rsp_valid);
   assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cache_en && gnt_ls) |=> (!rsp_hit && !upd_valid));
   assert_locked_noalloc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_lock && gnt_ls && !hit) |=> !upd_valid);
endmodule

// File: tb/tb_mei_tag_ctrl.sv
`timescale 1ns/1ps
module tb_mei_tag_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        cache_en = 1'b1, cache_lock = 1'b0, flash_req = 1'b0;
   logic        ls_valid = 1'b0, ls_write = 1'b0;
   logic [6:0]  ls_index = '0;
   logic [19:0] ls_tag = '0;
   logic [2:0]  victim_way = 3'd7;
   logic        ls_stall, rsp_valid, rsp_hit;
   logic [2:0]  rsp_way;
   logic        snp_valid = 1'b0, snp_inval = 1'b0;
   logic [6:0]  snp_index = '0;
   logic [19:0] snp_tag = '0;
   logic        snp_hit;
   logic        linv_valid = 1'b0;
   logic [6:0]  linv_index = '0;
   logic [2:0]  linv_way = '0;
   logic        co_valid, upd_valid, flash_busy;
   logic [6:0]  co_index, upd_index;
   logic [2:0]  co_way, upd_way;
   logic [1:0]  upd_state;

   mei_tag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cache_lock(cache_lock),
      .flash_req(flash_req), .ls_valid(ls_valid), .ls_index(ls_index),
      .ls_tag(ls_tag), .ls_write(ls_write), .victim_way(victim_way),
      .ls_stall(ls_stall), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_way(rsp_way), .snp_valid(snp_valid), .snp_index(snp_index),
      .snp_tag(snp_tag), .snp_inval(snp_inval), .snp_hit(snp_hit),
      .linv_valid(linv_valid), .linv_index(linv_index), .linv_way(linv_way),
      .co_valid(co_valid), .co_index(co_index), .co_way(co_way),
      .upd_valid(upd_valid), .upd_index(upd_index), .upd_way(upd_way),
      .upd_state(upd_state), .flash_busy(flash_busy)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ls_op(input logic [6:0] idx, input logic [19:0] tag, input logic wr);
      @(negedge clk);
      ls_valid = 1'b1; ls_index = idx; ls_tag = tag; ls_write = wr;
      #1;
      while (ls_stall) begin
         @(negedge clk); #1;
      end
      @(posedge clk);
      @(negedge clk);
      ls_valid = 1'b0;
   endtask

   task automatic snp_op(input logic [6:0] idx, input logic [19:0] tag, input logic inv);
      @(negedge clk);
      snp_valid = 1'b1; snp_index = idx; snp_tag = tag; snp_inval = inv;
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [6:0]  idx;
      logic [19:0] tag;
      logic        wr;
      logic        hit;
      logic [2:0]  way;
      logic        upd;
      logic [1:0]  st;
   } vec_t;

   // state codes: 0 Invalid, 1 Exclusive, 2 Modified
   localparam vec_t VEC [6] = '{
      '{7'd5, 20'h100, 1'b0, 1'b0, 3'd0, 1'b1, 2'd1},
      '{7'd5, 20'h100, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0},
      '{7'd5, 20'h200, 1'b1, 1'b0, 3'd1, 1'b1, 2'd2},
      '{7'd5, 20'h100, 1'b1, 1'b1, 3'd0, 1'b1, 2'd2},
      '{7'd5, 20'h200, 1'b0, 1'b1, 3'd1, 1'b0, 2'd0},
      '{7'd9, 20'h100, 1'b0, 1'b0, 3'd0, 1'b1, 2'd1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("reset rsp_valid R1", rsp_valid, 0);
      chk("reset flash_busy R8", flash_busy, 0);
      chk("reset co_valid R4", co_valid, 0);
      chk("reset upd_valid R2", upd_valid, 0);
      chk("reset ls_stall R3", ls_stall, 0);

      // table walk: allocation, hits, store upgrade (R1 R2 R6 R7)
      foreach (VEC[i]) begin
         ls_op(VEC[i].idx, VEC[i].tag, VEC[i].wr);
         chk("table rsp_hit R1", rsp_hit, VEC[i].hit);
         chk("table rsp_way R1", rsp_way, VEC[i].way);
         chk("table upd_valid R7", upd_valid, VEC[i].upd);
         if (VEC[i].upd) chk("table upd_state R2", upd_state, VEC[i].st);
      end

      // fill remaining ways of set 5 (R6)
      for (int i = 0; i < 6; i++) begin
         ls_op(7'd5, 20'h300 + 20'(i), 1'b0);
         chk("fill way R6", rsp_way, 32'(i + 2));
      end
      victim_way = 3'd3;
      ls_op(7'd5, 20'h900, 1'b0);
      chk("full set uses victim R6", rsp_way, 3);
      chk("clean victim no castout R6", co_valid, 0);
      victim_way = 3'd0;
      ls_op(7'd5, 20'hA00, 1'b1);
      chk("dirty victim castout R6", co_valid, 1);
      chk("dirty victim castout way R6", co_way, 0);
      chk("dirty victim castout set R6", co_index, 5);
      chk("store alloc state R6", upd_state, 2);

      // snoop colliding with a load, read snoop on Modified way 1
      @(negedge clk);
      snp_valid = 1'b1; snp_index = 7'd5; snp_tag = 20'h200; snp_inval = 1'b0;
      ls_valid = 1'b1; ls_index = 7'd5; ls_tag = 20'hA00; ls_write = 1'b0;
      #1;
      chk("collision stall R3", ls_stall, 1);
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
      chk("read snoop dirty hit R4", snp_hit, 1);
      chk("read snoop castout R4", co_valid, 1);
      chk("read snoop castout way R4", co_way, 1);
      chk("read snoop to Exclusive R4", upd_state, 1);
      chk("no load during snoop R3", rsp_valid, 0);
      #1;
      chk("castout extra stall R4", ls_stall, 1);
      @(posedge clk);
      @(negedge clk);
      chk("no load during castout R4", rsp_valid, 0);
      #1;
      chk("stall released R4", ls_stall, 0);
      @(posedge clk);
      @(negedge clk);
      ls_valid = 1'b0;
      chk("held load served R3", rsp_valid, 1);
      chk("held load hits R3", rsp_hit, 1);

      snp_op(7'd5, 20'h200, 1'b1);
      chk("inval snoop clean hit R5", snp_hit, 1);
      chk("inval snoop clean no castout R5", co_valid, 0);
      chk("inval snoop clean to Invalid R5", upd_state, 0);
      snp_op(7'd5, 20'h302, 1'b0);
      chk("read snoop clean hit R5", snp_hit, 1);
      chk("read snoop clean no write R5", upd_valid, 0);
      chk("read snoop clean no castout R5", co_valid, 0);
      ls_op(7'd5, 20'h200, 1'b0);
      chk("invalidated line misses R5", rsp_hit, 0);
      chk("refill takes free way R6", rsp_way, 1);
      snp_op(7'd5, 20'hA00, 1'b1);
      chk("inval snoop dirty castout R4", co_valid, 1);
      chk("inval snoop dirty to Invalid R4", upd_state, 0);

      // per-line invalidate against a load
      @(negedge clk);
      linv_valid = 1'b1; linv_index = 7'd9; linv_way = 3'd0;
      ls_valid = 1'b1; ls_index = 7'd9; ls_tag = 20'h100; ls_write = 1'b0;
      #1;
      chk("line inval stalls load R9", ls_stall, 1);
      @(posedge clk);
      @(negedge clk);
      linv_valid = 1'b0;
      chk("line inval write R9", upd_valid, 1);
      chk("line inval way R9", upd_way, 0);
      chk("line inval state R9", upd_state, 0);
      @(posedge clk);
      @(negedge clk);
      ls_valid = 1'b0;
      chk("line gone after inval R9", rsp_hit, 0);

      // disabled
      cache_en = 1'b0;
      ls_op(7'd9, 20'h100, 1'b0);
      chk("disabled no hit R10", rsp_hit, 0);
      chk("disabled no write R10", upd_valid, 0);
      snp_op(7'd9, 20'h100, 1'b1);
      chk("disabled snoop no hit R10", snp_hit, 0);
      chk("disabled snoop no write R10", upd_valid, 0);
      cache_en = 1'b1;
      ls_op(7'd9, 20'h100, 1'b0);
      chk("contents kept while off R10", rsp_hit, 1);

      // locked
      cache_lock = 1'b1;
      ls_op(7'd30, 20'h77, 1'b0);
      chk("locked miss R11", rsp_hit, 0);
      chk("locked miss no write R11", upd_valid, 0);
      ls_op(7'd30, 20'h77, 1'b0);
      chk("locked miss repeats R11", rsp_hit, 0);
      ls_op(7'd9, 20'h100, 1'b1);
      chk("locked store hit R11", rsp_hit, 1);
      chk("locked store upgrade R7", upd_state, 2);
      cache_lock = 1'b0;

      // flash invalidate
      @(negedge clk);
      flash_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      flash_req = 1'b0;
      chk("flash starts R8", flash_busy, 1);
      ls_valid = 1'b1; ls_index = 7'd5; ls_tag = 20'h300; ls_write = 1'b0;
      #1;
      chk("flash stalls load R8", ls_stall, 1);
      begin
         int busy_cycles = 0;
         while (flash_busy && busy_cycles < 1000) begin
            busy_cycles++;
            @(negedge clk);
         end
         chk("flash length R8", busy_cycles, 128);
      end
      #1;
      @(posedge clk);
      @(negedge clk);
      ls_valid = 1'b0;
      chk("after flash miss R8", rsp_hit, 0);
      chk("after flash first way R8", rsp_way, 0);
      ls_op(7'd9, 20'h100, 1'b0);
      chk("after flash other set miss R8", rsp_hit, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule